// File: doc/BRIEF.md
# DMA Channel Activation Controller

This block is the per-channel front end of a DMA controller. It decides when a channel may start a transfer and where the channel's selected internal interrupt goes. A transfer can be requested by one of two sources. The first is an active-low external request pin, sensed either on its level or on a falling edge. The second is an internal interrupt line. Address generation, byte counting and bus cycles stay in a separate transfer engine. The engine receives a one-cycle start pulse from this block and reports back a busy level, a normal transfer-end pulse and a forced-termination pulse.

Software reaches a small control register through a read/write port. The register holds a channel enable, a master enable, a bit that lets the DMA consume the internal interrupt, a sense-mode bit and a source-select bit. A cleared enable bit must be read back as zero before a later write of one can set it again. This rule protects read-modify-write sequences that are interleaved by several interrupt handlers. Once the channel is disabled, the internal interrupt always goes to the CPU.

Top module: `dma_chan_activator`

## Requirements
- R1: Reset clears every control field to 0 (`reg_rdata` reads 5'b00000) and drives `start_req`, `irq_clr` and `cpu_irq` low. Each enable bit counts as already read as zero, so the first write of one after reset takes effect.
- R2: Control field layout in `reg_wdata`/`reg_rdata`: bit0 channel enable, bit1 master enable, bit2 DMA-consumes-interrupt, bit3 sense mode (1 = falling edge, 0 = low level), bit4 source (1 = internal interrupt, 0 = request pin). The three mode bits are written directly and read back as written.
- R3: A write of 1 to either enable bit is ignored unless a read returned that bit as 0 after the bit was last cleared, whether by a write of 0 or by the DMA. Setting the bit rearms the rule.
- R4: A `xfer_done` pulse clears the channel enable. A `force_stop` pulse clears both the channel enable and the master enable.
- R5: In level mode, a low on the request pin starts a transfer only while both enables are set. A low that is already present before enabling is accepted. While the pin stays low, a new start follows every completed transfer.
- R6: In edge mode, the first activation after enabling is taken on a low level. Each later activation needs the synchronized pin to be high on one clock and low on the next, so a pin held low gives only one start.
- R7: With the internal source selected, both enables set and the consume bit set, the CPU output stays low. Each accepted transfer then gives exactly one `irq_clr` pulse after its busy period ends.
- R8: Whenever the channel or master enable is clear, `cpu_irq` follows `int_irq`, whatever the value of the consume bit.
- R9: If `force_stop` arrives while an internal-interrupt transfer is in flight, no `irq_clr` is issued for that transfer.
- R10: `start_req` is a one-cycle pulse and is never raised while `xfer_busy` was high at the deciding edge. A request that arrives during busy stays pending and fires once busy falls.
- R11: An internal interrupt that is already high before the enable write is accepted as an activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_req_n | input | 1 | Active-low external transfer request, asynchronous |
| int_irq | input | 1 | Selected internal interrupt request |
| xfer_busy | input | 1 | Transfer engine busy |
| xfer_done | input | 1 | Normal end of transfer pulse |
| force_stop | input | 1 | Forced termination pulse |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe |
| reg_wdata | input | 5 | Control register write data |
| reg_rdata | output | 5 | Control register contents |
| start_req | output | 1 | One-cycle transfer start request |
| irq_clr | output | 1 | Interrupt-flag clear strobe |
| cpu_irq | output | 1 | Interrupt forwarded to the CPU |

## Verification
The assertions take for granted a few things about the engine. It raises `xfer_busy` by the edge after `start_req` and keeps it high for at least one cycle. It does not assert `xfer_done` or `force_stop` in the same cycle as a start. Register reads and writes never share a cycle. The bench meets all of this with a behavioural engine that loads a busy counter on each observed start and with a separate busy override used to hold requests off. Every input change, including each read and write strobe, is driven on the falling clock edge. The interrupt source is modelled as a flag that the bench drops when it sees `irq_clr`.

// File: rtl/dma_chan_activator.sv
module dma_chan_activator #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_req_n,
  input  logic       int_irq,
  input  logic       xfer_busy,
  input  logic       xfer_done,
  input  logic       force_stop,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [4:0] reg_wdata,
  output logic [4:0] reg_rdata,
  output logic       start_req,
  output logic       irq_clr,
  output logic       cpu_irq
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic pin_lo, pin_prev_lo;
  logic ce, me, steal, edge_sel, src_int;
  logic rz_ce, rz_me;
  logic act_q, arm_lvl, pending, inflight, seen_busy, own_clr, aborted;

  wire active   = ce & me;
  wire act_rise = active & ~act_q;
  wire ext_hit  = edge_sel ? (pin_lo & (arm_lvl | act_rise | ~pin_prev_lo)) : pin_lo;
  wire hit      = src_int ? int_irq : ext_hit;
  wire accept   = active & hit & ~pending & ~inflight & ~irq_clr;
  wire fire     = pending & active & ~xfer_busy;
  wire finish   = inflight & seen_busy & ~xfer_busy;

  assign pin_lo    = ~sync_q[SYNC_STAGES-1];
  assign reg_rdata = {src_int, edge_sel, steal, me, ce};
  assign cpu_irq   = int_irq & ~(active & steal & src_int);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= '1;
      pin_prev_lo <= 1'b0;
    end else begin
      sync_q      <= {sync_q[SYNC_STAGES-2:0], ext_req_n};
      pin_prev_lo <= pin_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce <= 1'b0; me <= 1'b0; steal <= 1'b0; edge_sel <= 1'b0; src_int <= 1'b0;
      rz_ce <= 1'b1; rz_me <= 1'b1;
    end else begin
      if (reg_wr) begin
        steal    <= reg_wdata[2];
        edge_sel <= reg_wdata[3];
        src_int  <= reg_wdata[4];
        if (!reg_wdata[0]) ce <= 1'b0;
        else if (rz_ce) begin ce <= 1'b1; rz_ce <= 1'b0; end
        if (!reg_wdata[1]) me <= 1'b0;
        else if (rz_me) begin me <= 1'b1; rz_me <= 1'b0; end
      end else if (reg_rd) begin
        if (!ce) rz_ce <= 1'b1;
        if (!me) rz_me <= 1'b1;
      end
      if (xfer_done || force_stop) ce <= 1'b0;
      if (force_stop) me <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; arm_lvl <= 1'b0; pending <= 1'b0; start_req <= 1'b0;
    end else begin
      act_q     <= active;
      start_req <= fire;
      if (!active) arm_lvl <= 1'b0;
      else if (act_rise) arm_lvl <= 1'b1;
      if (accept && !src_int) arm_lvl <= 1'b0;
      if (!active || fire) pending <= 1'b0;
      else if (accept) pending <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight <= 1'b0; seen_busy <= 1'b0; own_clr <= 1'b0; aborted <= 1'b0; irq_clr <= 1'b0;
    end else begin
      irq_clr <= 1'b0;
      if (fire) begin
        inflight  <= 1'b1;
        seen_busy <= 1'b0;
        aborted   <= 1'b0;
        own_clr   <= src_int & steal;
      end else if (finish) begin
        inflight <= 1'b0;
        irq_clr  <= own_clr & ~aborted;
      end else begin
        if (inflight && xfer_busy) seen_busy <= 1'b1;
        if (inflight && force_stop) aborted <= 1'b1;
      end
    end
  end

  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !start_req);
  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_req) |-> !$past(xfer_busy));
  // R4
  force_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_stop |=> (reg_rdata[1:0] == 2'b00));
  // R3
  ce_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[0]) |-> $past(reg_wr && reg_wdata[0]));
  // R8
  route_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_irq && !(reg_rdata[0] && reg_rdata[1])) |-> cpu_irq);
  // R7
  steal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[4] && reg_rdata[2] && reg_rdata[1] && reg_rdata[0]) |-> !cpu_irq);
  // R9
  abort_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |-> !$past(aborted));

endmodule

// File: tb/dma_chan_activator_test.sv
`timescale 1ns/1ps
module dma_chan_activator_test;

  logic clk = 0, rst_n = 0;
  logic ext_req_n = 1, int_irq = 0, xfer_done = 0, force_stop = 0;
  logic reg_wr = 0, reg_rd = 0, force_busy = 0;
  logic [4:0] reg_wdata = 0, reg_rdata;
  logic start_req, irq_clr, cpu_irq, xfer_busy;
  int busy_cnt = 0, busy_len = 2;
  int n_chk = 0, n_bad = 0, starts = 0, clrs = 0, cpu_cnt = 0, dbl = 0, busy_start = 0;
  logic prev_start = 0, finished = 0;

  always #2 clk = ~clk;

  assign xfer_busy = force_busy || (busy_cnt != 0);

  dma_chan_activator uut (
    .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .int_irq(int_irq),
    .xfer_busy(xfer_busy), .xfer_done(xfer_done), .force_stop(force_stop),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .start_req(start_req), .irq_clr(irq_clr), .cpu_irq(cpu_irq)
  );

  always @(negedge clk) begin
    if (start_req) begin
      starts++;
      if (prev_start) dbl++;
      if (xfer_busy) busy_start++;
    end
    prev_start = start_req;
    if (irq_clr) begin clrs++; int_irq = 0; end
    if (cpu_irq) cpu_cnt++;
    if (busy_cnt > 0) busy_cnt--;
    if (start_req) busy_cnt = busy_len;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(output logic [4:0] v);
    @(negedge clk); reg_rd = 1; v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic enable(logic [4:0] d);
    logic [4:0] v;
    rd(v); wr(d);
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done = 1; @(negedge clk); xfer_done = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); force_stop = 1; @(negedge clk); force_stop = 0;
  endtask

  task automatic t_reset();
    logic [4:0] v;
    chk("R1 start_req", start_req, 0);
    chk("R1 irq_clr", irq_clr, 0);
    chk("R1 cpu_irq", cpu_irq, 0);
    rd(v);
    chk("R1 reset fields", v, 0);
  endtask

  task automatic t_regs();
    logic [4:0] v;
    wr(5'b11111); rd(v);
    chk("R2 readback all set", v, 5'b11111);
    wr(5'b11100); wr(5'b11111); rd(v);
    chk("R3 set ignored without read", v, 5'b11100);
    wr(5'b11111); rd(v);
    chk("R3 set after zero read", v, 5'b11111);
    wr(5'b00000); rd(v);
    chk("R2 cleared", v, 0);
  endtask

  task automatic t_dma_clear();
    logic [4:0] v;
    enable(5'b00011); pulse_done(); rd(v);
    chk("R4 done clears channel enable", v, 5'b00010);
    enable(5'b00011); pulse_stop(); rd(v);
    chk("R4 stop clears both enables", v, 5'b00000);
  endtask

  task automatic t_level();
    int s0;
    s0 = starts;
    ext_req_n = 0; cyc(6);
    chk("R5 no start while disabled", starts - s0, 0);
    enable(5'b00011); cyc(20);
    n_chk++;
    if (starts - s0 < 2) begin
      n_bad++; $display("FAIL R5 level retrigger: actual %0d expected >=2", starts - s0);
    end
    wr(5'b00000); ext_req_n = 1; cyc(6);
  endtask

  task automatic t_edge();
    int s0;
    s0 = starts;
    ext_req_n = 0; cyc(3);
    enable(5'b01011); cyc(20);
    chk("R6 first start on low level", starts - s0, 1);
    ext_req_n = 1; cyc(4); ext_req_n = 0; cyc(20);
    chk("R6 second start on falling edge", starts - s0, 2);
    ext_req_n = 1; cyc(4); ext_req_n = 0; cyc(20);
    chk("R6 third start on falling edge", starts - s0, 3);
    wr(5'b00000); ext_req_n = 1; cyc(6);
  endtask

  task automatic t_busy();
    int s0;
    force_busy = 1; cyc(2);
    s0 = starts;
    ext_req_n = 0;
    enable(5'b00011); cyc(10);
    chk("R10 held off while busy", starts - s0, 0);
    force_busy = 0; cyc(2);
    chk("R10 pending fires after busy", starts - s0, 1);
    cyc(20);
    chk("R10 single-cycle pulses", dbl, 0);
    chk("R10 no start during busy", busy_start, 0);
    wr(5'b00000); ext_req_n = 1; cyc(6);
  endtask

  task automatic t_steal();
    int s0, c0;
    s0 = starts; c0 = clrs;
    int_irq = 1; cyc(2);
    chk("R8 disabled irq to cpu", cpu_irq, 1);
    enable(5'b10111);
    cpu_cnt = 0; cyc(20);
    chk("R11 pre-enable irq accepted", starts - s0, 1);
    chk("R7 one clear strobe", clrs - c0, 1);
    int_irq = 1; cyc(20);
    chk("R7 second transfer", starts - s0, 2);
    chk("R7 second clear strobe", clrs - c0, 2);
    chk("R7 nothing to cpu", cpu_cnt, 0);
  endtask

  task automatic t_route();
    int s0;
    pulse_done(); cyc(2);
    s0 = starts;
    int_irq = 1; cyc(3);
    chk("R8 irq routed after end", cpu_irq, 1);
    chk("R8 no start when disabled", starts - s0, 0);
    int_irq = 0; cyc(2);
  endtask

  task automatic t_abort();
    int s0, c0;
    logic [4:0] v;
    busy_len = 6;
    enable(5'b10111);
    s0 = starts; c0 = clrs;
    int_irq = 1;
    for (int i = 0; i < 10 && starts == s0; i++) cyc(1);
    chk("R9 transfer started", starts - s0, 1);
    pulse_stop(); cyc(12);
    chk("R9 no clear after abort", clrs - c0, 0);
    chk("R9 irq left for cpu", cpu_irq, 1);
    rd(v);
    chk("R4 enables cleared by stop", v[1:0], 0);
    int_irq = 0; busy_len = 2; cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    t_reset();
    t_regs();
    t_dma_clear();
    t_level();
    t_edge();
    t_busy();
    t_steal();
    t_route();
    t_abort();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule